// File: doc/BRIEF.md
# Multicycle 32-bit Processor Core

This block is a 32-bit processor core that runs a small load/store instruction subset over several clock cycles per instruction. A single ALU serves the program counter increment, the branch target, the address of a load or store and the arithmetic of register-to-register operations, each in a different cycle. One memory port carries both instruction fetches and data accesses. A state machine steps through fetch, decode, execute, memory and write-back states and drives the datapath through a small bundle of control strobes.

The number of cycles depends on the instruction class:

| Class | Cycles |
|---|---|
| Branch | 3 |
| Jump | 3 |
| Register-to-register | 4 |
| Store | 4 |
| Load | 5 |
| Undefined opcode | 2 |

The core is placed next to a word-organised memory whose read data is valid in the same cycle as the address. A write takes effect at the clock edge that ends the cycle in which the write strobe is high. Addresses are byte addresses, and bits [1:0] are always zero for aligned code and data.

Top module: `mc_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the core fetches from address 0 with `memRead`=1 and `memWrite`=0. All 32 general registers are zero after reset.
- R2: Every instruction starts with one fetch cycle. In that cycle `memAddr` equals the PC and `memRead`=1. The next sequential fetch is at PC+4.
- R3: A register-to-register instruction (opcode [31:26]=0x00) takes 4 cycles and writes the register named in bits [15:11]. The operation is chosen by funct bits [5:0]: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0). The two sources are the registers named in bits [25:21] and [20:16].
- R4: A load (opcode 0x23) takes 5 cycles. In its 4th cycle `memRead`=1 and `memAddr` = reg[25:21] + sign-extended bits [15:0]. The word read is written to the register named in bits [20:16].
- R5: A store (opcode 0x2B) takes 4 cycles. In its 4th cycle `memWrite`=1, with the address formed as for a load and `memWrData` set to the register named in bits [20:16].
- R6: A branch-if-equal (opcode 0x04) takes 3 cycles. If the two source registers are equal, the next fetch is at PC+4 + (sign-extended bits [15:0] shifted left 2). Otherwise it is at PC+4.
- R7: A jump (opcode 0x02) takes 3 cycles. The next fetch is at {upper 4 bits of PC+4, bits [25:0], 2'b00}.
- R8: Any other opcode takes 2 cycles, writes no register and no memory, and is followed by a fetch at PC+4.
- R9: `memRead` and `memWrite` are never high together. Outside the cycles named in R2, R4 and R5, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| memAddr | output | 32 | Byte address of the shared memory port |
| memRead | output | 1 | Read strobe (instruction fetch or load) |
| memWrite | output | 1 | Write strobe (store) |
| memWrData | output | 32 | Store data |
| memRdData | input | 32 | Read data, valid in the same cycle as the address |

## Verification
Every result of this core shows up at the memory port in a cycle fixed by its instruction class. A fetch address appears in the first cycle of an instruction. A load address appears in the 4th cycle of a load, and a store address and data appear in the 4th cycle of a store. A branch or jump decision shows up in the fetch address of the next instruction, three cycles after the earlier fetch.

The bench model runs each fetched instruction at the architectural level and queues one expected port state per cycle. It pops one entry at every falling edge, so each strobe, address and data word is compared mid-cycle in exactly the cycle it is due. Register contents, including the absence of a write by an undefined opcode, are observed through later stores and through a final comparison of the data region.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;

  localparam logic [5:0] OP_REG    = 6'h00;
  localparam logic [5:0] OP_JUMP   = 6'h02;
  localparam logic [5:0] OP_BRANCH = 6'h04;
  localparam logic [5:0] OP_LOAD   = 6'h23;
  localparam logic [5:0] OP_STORE  = 6'h2B;

  // ALU operand-B selector codes
  localparam logic [1:0] SRCB_REG   = 2'b00;
  localparam logic [1:0] SRCB_FOUR  = 2'b01;
  localparam logic [1:0] SRCB_IMM   = 2'b10;
  localparam logic [1:0] SRCB_IMMX4 = 2'b11;

  // next-PC selector codes
  localparam logic [1:0] PCSEL_ALU  = 2'b00;
  localparam logic [1:0] PCSEL_HELD = 2'b01;
  localparam logic [1:0] PCSEL_JUMP = 2'b10;

  // ALU function class
  localparam logic [1:0] ALUCLS_ADD  = 2'b00;
  localparam logic [1:0] ALUCLS_SUB  = 2'b01;
  localparam logic [1:0] ALUCLS_FUNC = 2'b10;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_ADDR, S_LDMEM, S_LDWB,
    S_STMEM, S_EXEC, S_RWB, S_BRANCH, S_JUMP
  } state_e;

  typedef struct packed {
    logic       pcWrite;
    logic       pcWriteCond;
    logic       iorD;
    logic       memRead;
    logic       memWrite;
    logic       irWrite;
    logic       memToReg;
    logic       regDst;
    logic       regWrite;
    logic       aluSrcA;
    logic [1:0] aluSrcB;
    logic [1:0] aluCls;
    logic [1:0] pcSel;
  } ctrl_t;

endpackage

// File: rtl/mc_alu.sv
`timescale 1ns/1ps
module mc_alu
  import mc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]      aluCls,
  input  logic [3:0]      funcLow,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic [XLEN-1:0] result,
  output logic            zero
);

  logic [2:0] sel;

  // reduced decode of class and low funct bits into a 3-bit select
  always_comb begin
    sel[2] = aluCls[0] | (aluCls[1] & funcLow[1]);
    sel[1] = ~aluCls[1] | ~funcLow[2];
    sel[0] = aluCls[1] & (funcLow[0] | funcLow[3]);
  end

  always_comb begin
    unique case (sel)
      3'b000:  result = opA & opB;
      3'b001:  result = opA | opB;
      3'b110:  result = opA - opB;
      3'b111:  result = {{(XLEN-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: result = opA + opB;
    endcase
  end

  assign zero = (result == '0);

endmodule

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
module mc_regfile #(
  parameter int XLEN    = 32,
  parameter int REG_CNT = 32,
  localparam int REG_AW = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] rdIdxA,
  input  logic [REG_AW-1:0] rdIdxB,
  output logic [XLEN-1:0]   rdDataA,
  output logic [XLEN-1:0]   rdDataB,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrIdx,
  input  logic [XLEN-1:0]   wrData
);

  logic [XLEN-1:0] regs [REG_CNT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_CNT; i++) regs[i] <= '0;
    end else if (wrEn) begin
      regs[wrIdx] <= wrData;
    end
  end

  assign rdDataA = regs[rdIdxA];
  assign rdDataB = regs[rdIdxB];

endmodule

// File: rtl/mc_control.sv
`timescale 1ns/1ps
module mc_control
  import mc_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic [5:0] opcode,
  output ctrl_t  ctrl,
  output state_e state
);

  state_e nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_FETCH;
    else       state <= nextState;
  end

  always_comb begin
    nextState = S_FETCH;
    unique case (state)
      S_FETCH:  nextState = S_DECODE;
      S_DECODE: begin
        unique case (opcode)
          OP_REG:              nextState = S_EXEC;
          OP_LOAD, OP_STORE:   nextState = S_ADDR;
          OP_BRANCH:           nextState = S_BRANCH;
          OP_JUMP:             nextState = S_JUMP;
          default:             nextState = S_FETCH;
        endcase
      end
      S_ADDR:   nextState = (opcode == OP_LOAD) ? S_LDMEM : S_STMEM;
      S_LDMEM:  nextState = S_LDWB;
      S_EXEC:   nextState = S_RWB;
      default:  nextState = S_FETCH;
    endcase
  end

  always_comb begin
    ctrl = '0;
    unique case (state)
      S_FETCH: begin
        ctrl.memRead = 1'b1;
        ctrl.irWrite = 1'b1;
        ctrl.aluSrcB = SRCB_FOUR;
        ctrl.aluCls  = ALUCLS_ADD;
        ctrl.pcSel   = PCSEL_ALU;
        ctrl.pcWrite = 1'b1;
      end
      S_DECODE: begin
        ctrl.aluSrcB = SRCB_IMMX4;   // branch target precomputed
        ctrl.aluCls  = ALUCLS_ADD;
      end
      S_ADDR: begin
        ctrl.aluSrcA = 1'b1;
        ctrl.aluSrcB = SRCB_IMM;
        ctrl.aluCls  = ALUCLS_ADD;
      end
      S_LDMEM: begin
        ctrl.iorD    = 1'b1;
        ctrl.memRead = 1'b1;
      end
      S_LDWB: begin
        ctrl.regWrite = 1'b1;
        ctrl.memToReg = 1'b1;
      end
      S_STMEM: begin
        ctrl.iorD     = 1'b1;
        ctrl.memWrite = 1'b1;
      end
      S_EXEC: begin
        ctrl.aluSrcA = 1'b1;
        ctrl.aluSrcB = SRCB_REG;
        ctrl.aluCls  = ALUCLS_FUNC;
      end
      S_RWB: begin
        ctrl.regDst   = 1'b1;
        ctrl.regWrite = 1'b1;
      end
      S_BRANCH: begin
        ctrl.aluSrcA     = 1'b1;
        ctrl.aluSrcB     = SRCB_REG;
        ctrl.aluCls      = ALUCLS_SUB;
        ctrl.pcWriteCond = 1'b1;
        ctrl.pcSel       = PCSEL_HELD;
      end
      S_JUMP: begin
        ctrl.pcWrite = 1'b1;
        ctrl.pcSel   = PCSEL_JUMP;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mc_datapath.sv
`timescale 1ns/1ps
module mc_datapath
  import mc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int REG_CNT = 32,
  localparam int REG_AW = $clog2(REG_CNT)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_t           ctrl,
  input  logic [XLEN-1:0] memRdData,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWrData,
  output logic [5:0]      opcode,
  output logic [XLEN-1:0] pcOut
);

  logic [XLEN-1:0] pc, instr, mdr, regA, regB, aluOut;
  logic [XLEN-1:0] rdDataA, rdDataB, srcA, srcB, aluRes, pcNext;
  logic [XLEN-1:0] immExt, jumpTarget, wrData;
  logic [REG_AW-1:0] wrIdx;
  logic aluZero, pcEn;

  assign immExt     = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign jumpTarget = {pc[XLEN-1:28], instr[25:0], 2'b00};
  assign opcode     = instr[31:26];
  assign pcOut      = pc;

  assign srcA = ctrl.aluSrcA ? regA : pc;

  always_comb begin
    unique case (ctrl.aluSrcB)
      SRCB_REG:  srcB = regB;
      SRCB_FOUR: srcB = XLEN'(4);
      SRCB_IMM:  srcB = immExt;
      default:   srcB = immExt << 2;
    endcase
  end

  mc_alu #(.XLEN(XLEN)) u_alu (
    .aluCls  (ctrl.aluCls),
    .funcLow (instr[3:0]),
    .opA     (srcA),
    .opB     (srcB),
    .result  (aluRes),
    .zero    (aluZero)
  );

  always_comb begin
    unique case (ctrl.pcSel)
      PCSEL_ALU:  pcNext = aluRes;
      PCSEL_HELD: pcNext = aluOut;
      default:    pcNext = jumpTarget;
    endcase
  end

  assign pcEn = ctrl.pcWrite | (ctrl.pcWriteCond & aluZero);

  assign wrIdx  = ctrl.regDst ? instr[11 +: REG_AW] : instr[16 +: REG_AW];
  assign wrData = ctrl.memToReg ? mdr : aluOut;

  mc_regfile #(.XLEN(XLEN), .REG_CNT(REG_CNT)) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .rdIdxA  (instr[21 +: REG_AW]),
    .rdIdxB  (instr[16 +: REG_AW]),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB),
    .wrEn    (ctrl.regWrite),
    .wrIdx   (wrIdx),
    .wrData  (wrData)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc     <= '0;
      instr  <= '0;
      mdr    <= '0;
      regA   <= '0;
      regB   <= '0;
      aluOut <= '0;
    end else begin
      if (pcEn)         pc    <= pcNext;
      if (ctrl.irWrite) instr <= memRdData;
      mdr    <= memRdData;
      regA   <= rdDataA;
      regB   <= rdDataB;
      aluOut <= aluRes;
    end
  end

  assign memAddr   = ctrl.iorD ? aluOut : pc;
  assign memWrData = regB;

endmodule

// File: rtl/mc_core.sv
`timescale 1ns/1ps
module mc_core
  import mc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int REG_CNT = 32
) (
  input  logic            clk,
  input  logic            rstN,
  output logic [XLEN-1:0] memAddr,
  output logic            memRead,
  output logic            memWrite,
  output logic [XLEN-1:0] memWrData,
  input  logic [XLEN-1:0] memRdData
);

  ctrl_t           ctrl;
  state_e          state;
  logic [5:0]      opcode;
  logic [XLEN-1:0] pcVal;

  mc_control u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opcode (opcode),
    .ctrl   (ctrl),
    .state  (state)
  );

  mc_datapath #(.XLEN(XLEN), .REG_CNT(REG_CNT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .opcode    (opcode),
    .pcOut     (pcVal)
  );

  assign memRead  = ctrl.memRead;
  assign memWrite = ctrl.memWrite;

endmodule

// File: rtl/mc_core_chk.sv
`timescale 1ns/1ps
module mc_core_chk
  import mc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input state_e          state,
  input logic [5:0]      opcode,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] memAddr,
  input logic            memRead,
  input logic            memWrite
);

  logic knownOp;
  assign knownOp = (opcode == OP_REG) || (opcode == OP_LOAD) || (opcode == OP_STORE) ||
                   (opcode == OP_BRANCH) || (opcode == OP_JUMP);

  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (memRead && !memWrite && memAddr == '0));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FETCH) |=> (pc == $past(pc) + XLEN'(4)));

  p_decode_next_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FETCH) |=> (state == S_DECODE));

  p_exec_wb_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EXEC) |=> (state == S_RWB));

  p_load_wb_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_LDMEM) |=> (state == S_LDWB && !memRead && !memWrite));

  p_store_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> (state == S_STMEM));

  p_branch_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BRANCH) |=> (state == S_FETCH));

  p_jump_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_JUMP) |=> (state == S_FETCH && memAddr == pc));

  p_unknown_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DECODE && !knownOp) |=> (state == S_FETCH && pc == $past(pc)));

  p_one_port_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite));

endmodule

bind mc_core mc_core_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .state    (state),
  .opcode   (opcode),
  .pc       (pcVal),
  .memAddr  (memAddr),
  .memRead  (memRead),
  .memWrite (memWrite)
);

// File: tb/test_mc_core.sv
`timescale 1ns/1ps
module test_mc_core;

  localparam int MEM_WORDS = 256;
  localparam int RUN_CYCLES = 160;

  typedef struct {
    logic        rd;
    logic        wr;
    logic        chkAddr;
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] memAddr, memWrData, memRdData;
  logic        memRead, memWrite;

  logic [31:0] tbMem  [MEM_WORDS];
  logic [31:0] refMem [MEM_WORDS];
  logic [31:0] refReg [32];
  logic [31:0] refPc;
  exp_t        expQ[$];
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  assign memRdData = tbMem[memAddr[9:2]];
  always @(posedge clk) if (memWrite) tbMem[memAddr[9:2]] <= memWrData;

  mc_core i_mc_core (
    .clk       (clk),
    .rstN      (rstN),
    .memAddr   (memAddr),
    .memRead   (memRead),
    .memWrite  (memWrite),
    .memWrData (memWrData),
    .memRdData (memRdData)
  );

  function automatic logic [31:0] encR(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic pushExp(logic rd, logic wr, logic ca, logic [31:0] a, logic [31:0] d, string tag);
    exp_t e;
    e.rd = rd; e.wr = wr; e.chkAddr = ca; e.addr = a; e.data = d; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic pushIdle(int n, string tag);
    for (int i = 0; i < n; i++) pushExp(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, tag);
  endtask

  // architectural model: runs one instruction, queues its per-cycle port states
  task automatic stepModel();
    logic [31:0] ins, sext, npc, ea, res, va, vb;
    int rs, rt, rd;
    ins  = refMem[refPc[9:2]];
    rs   = int'(ins[25:21]);
    rt   = int'(ins[20:16]);
    rd   = int'(ins[15:11]);
    sext = {{16{ins[15]}}, ins[15:0]};
    va   = refReg[rs];
    vb   = refReg[rt];
    ea   = va + sext;
    npc  = refPc + 32'd4;
    pushExp(1'b1, 1'b0, 1'b1, refPc, 32'h0, "R2");
    case (ins[31:26])
      6'h00: begin
        case (ins[5:0])
          6'h20:   res = va + vb;
          6'h22:   res = va - vb;
          6'h24:   res = va & vb;
          6'h25:   res = va | vb;
          default: res = ($signed(va) < $signed(vb)) ? 32'd1 : 32'd0;
        endcase
        pushIdle(3, "R3");
        refReg[rd] = res;
      end
      6'h23: begin
        pushIdle(2, "R4");
        pushExp(1'b1, 1'b0, 1'b1, ea, 32'h0, "R4");
        pushIdle(1, "R4");
        refReg[rt] = refMem[ea[9:2]];
      end
      6'h2B: begin
        pushIdle(2, "R5");
        pushExp(1'b0, 1'b1, 1'b1, ea, vb, "R5");
        refMem[ea[9:2]] = vb;
      end
      6'h04: begin
        pushIdle(2, "R6");
        if (va == vb) npc = npc + (sext << 2);
      end
      6'h02: begin
        pushIdle(2, "R7");
        npc = {npc[31:28], ins[25:0], 2'b00};
      end
      default: pushIdle(1, "R8");
    endcase
    refPc = npc;
  endtask

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) tbMem[i] = 32'h0;
    // data region at byte 0x200
    tbMem[128] = 32'd5;
    tbMem[129] = 32'hFFFF_FFFD;
    tbMem[130] = 32'h0F0F_00FF;
    // program
    tbMem[0]  = encI(6'h23, 0, 1, 16'h200);   // r1 = 5
    tbMem[1]  = encI(6'h23, 0, 2, 16'h204);   // r2 = -3
    tbMem[2]  = encI(6'h23, 0, 3, 16'h208);
    tbMem[3]  = encR(1, 2, 4, 6'h20);
    tbMem[4]  = encR(1, 2, 5, 6'h22);
    tbMem[5]  = encR(3, 1, 6, 6'h24);
    tbMem[6]  = encR(3, 2, 7, 6'h25);
    tbMem[7]  = encR(2, 1, 8, 6'h2A);          // -3 < 5 -> 1
    tbMem[8]  = encR(1, 2, 9, 6'h2A);          // 5 < -3 -> 0
    tbMem[9]  = encI(6'h2B, 0, 4, 16'h20C);
    tbMem[10] = encI(6'h2B, 0, 5, 16'h210);
    tbMem[11] = encI(6'h04, 1, 2, 5);          // not taken
    tbMem[12] = encI(6'h04, 1, 1, 2);          // taken -> word 15
    tbMem[13] = encI(6'h2B, 0, 1, 16'h230);
    tbMem[14] = encI(6'h2B, 0, 1, 16'h234);
    tbMem[15] = {6'h3F, 5'd3, 5'd1, 5'd1, 5'd0, 6'h20}; // undefined opcode
    tbMem[16] = encI(6'h2B, 0, 1, 16'h224);
    tbMem[17] = {6'h02, 26'd21};
    tbMem[18] = encI(6'h2B, 0, 2, 16'h238);
    tbMem[19] = encI(6'h2B, 0, 2, 16'h238);
    tbMem[20] = encI(6'h2B, 0, 2, 16'h238);
    tbMem[21] = encI(6'h2B, 0, 6, 16'h214);
    tbMem[22] = encI(6'h2B, 0, 7, 16'h218);
    tbMem[23] = encI(6'h2B, 0, 8, 16'h21C);
    tbMem[24] = encI(6'h2B, 0, 9, 16'h220);
    tbMem[25] = encI(6'h04, 0, 0, -1);         // backward branch to itself
    for (int i = 0; i < MEM_WORDS; i++) refMem[i] = tbMem[i];
    for (int i = 0; i < 32; i++) refReg[i] = 32'h0;
    refPc = 32'h0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(memAddr == 32'h0, "R1", "reset memAddr", memAddr, 32'h0);
    check(memRead == 1'b1, "R1", "reset memRead", {31'h0, memRead}, 32'h1);
    check(memWrite == 1'b0, "R1", "reset memWrite", {31'h0, memWrite}, 32'h0);
    @(posedge clk);
    #1 rstN = 1'b1;

    for (int c = 0; c < RUN_CYCLES; c++) begin
      exp_t e;
      @(negedge clk);
      if (expQ.size() == 0) stepModel();
      e = expQ.pop_front();
      check(memRead === e.rd, e.tag, "memRead", {31'h0, memRead}, {31'h0, e.rd});
      check(memWrite === e.wr, e.tag, "memWrite", {31'h0, memWrite}, {31'h0, e.wr});
      check(!(memRead && memWrite), "R9", "strobe overlap", {30'h0, memRead, memWrite}, 32'h0);
      if (e.chkAddr) check(memAddr === e.addr, e.tag, "memAddr", memAddr, e.addr);
      if (e.wr) check(memWrData === e.data, e.tag, "memWrData", memWrData, e.data);
    end

    // stored words reflect loads, ALU results and the untouched register (R4, R5, R8)
    for (int w = 128; w < 144; w++)
      check(tbMem[w] === refMem[w], "R5", $sformatf("data word %0d", w), tbMem[w], refMem[w]);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 5000, RUN_CYCLES);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule